// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Its logical register numbers split into two regions: a low region of fixed registers that always map straight to storage, and an upper region of rotating registers whose names pass through a rotation base. When a loop iteration ends, the loop branch pulses `rotate`. The base then advances by one, so every rotating register is renamed at once and no value is copied. A value written as logical register n is read back as logical register n+1 after one rotation. Each rotating name therefore acts like one slot of a push-down stack, and older values stay readable under higher numbers until they wrap around.

There is one write port and two read ports. All three take logical numbers. Each read port has a registered output with a latency of one cycle. A synchronous `base_clr` input returns the mapping to its starting position. Storage is written so that an FPGA can map each read port onto its own block RAM copy.

Top module: `rot_regfile`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both read outputs are zero. Reset also sets the rotation base to zero.
- R2: A read presents its data on the clock edge that follows the address cycle, one cycle of latency. A fixed register (logical number below FIX_N, 8 by default) returns the last value written to that same number.
- R3: A pulse on `rotate` does not change any fixed register as seen through either read port.
- R4: Rotating logical numbers run from FIX_N to FIX_N+ROT_N-1 (8 to 23 by default). After one rotation, the value that was visible at rotating slot k (k = number − FIX_N) is visible at slot (k+1) mod ROT_N.
- R5: If `rotate` and a write fall in the same cycle, the write uses the base from before the rotation. One cycle later, the written value therefore appears one slot higher than the address that was written.
- R6: A read of the register being written in the same cycle returns the old contents. There is no write-through.
- R7: `base_clr` puts the base back to zero on the next edge and takes priority over `rotate`. Afterwards, every rotating slot k shows what it showed the last time the base was zero, plus any writes made since.
- R8: Logical numbers at or above FIX_N+ROT_N (24 to 31 by default) are unmapped. Writes to them change nothing, and reads from them return zero.
- R9: The two read ports work independently and may read any pair of addresses, including the same address, in the same cycle.
- R10: After ROT_N rotations the mapping is the same as it was before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_clr | input | 1 | Return the rotation base to zero |
| rotate | input | 1 | Advance the rotation base by one position (end of iteration) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | LW (5) | Logical register number to write |
| wr_data | input | DW (32) | Write data |
| rd_idx_a | input | LW (5) | Logical register number, read port A |
| rd_data_a | output | DW (32) | Registered read data, port A |
| rd_idx_b | input | LW (5) | Logical register number, read port B |
| rd_data_b | output | DW (32) | Registered read data, port B |

## Verification
Two pairs of functions can fall in the same cycle. A write can coincide with a rotation or a base clear, and a read can hit the register that is being written. The bench provokes both pairs on purpose, and also through a long run of mixed operations. It predicts the result with a model of logical contents that shifts the rotating slots, or shifts them back, at each edge after applying the write. The model never computes a physical index. For a write that meets a rotation, the bench checks that the value appears one slot higher. For a read that meets a write, it checks that the old value comes back and that the new value arrives on the following read.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Region a logical register number falls in
  typedef enum logic [1:0] {
    RGN_FIXED  = 2'd0,
    RGN_ROT    = 2'd1,
    RGN_UNMAP  = 2'd2
  } rrf_region_e;
endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int ROT_N = 16,
  parameter int BW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [BW-1:0] base
);
  localparam logic [BW-1:0] LAST = BW'(ROT_N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      base <= '0;
    end else if (step) begin
      base <= (base == LAST) ? '0 : base + 1'b1;
    end
  end
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate
  import rrf_pkg::*;
#(
  parameter int FIX_N = 8,
  parameter int ROT_N = 16,
  parameter int LW    = 5,
  parameter int PW    = 5,
  parameter int BW    = 4
) (
  input  logic [LW-1:0] lidx,
  input  logic [BW-1:0] base,
  output logic [PW-1:0] pidx,
  output logic          hit
);
  localparam int SW = ((LW > BW) ? LW : BW) + 1;

  rrf_region_e    rgn;
  logic [SW-1:0]  slot;
  logic [SW-1:0]  wrapped;

  always_comb begin
    if (SW'(lidx) < SW'(FIX_N))              rgn = RGN_FIXED;
    else if (SW'(lidx) < SW'(FIX_N + ROT_N)) rgn = RGN_ROT;
    else                                     rgn = RGN_UNMAP;

    // slot within the rotating window, then (slot - base) mod ROT_N
    slot    = SW'(lidx) - SW'(FIX_N);
    wrapped = slot + SW'(ROT_N) - SW'(base);
    if (wrapped >= SW'(ROT_N)) wrapped = wrapped - SW'(ROT_N);

    unique case (rgn)
      RGN_FIXED: begin pidx = PW'(lidx);                 hit = 1'b1; end
      RGN_ROT:   begin pidx = PW'(FIX_N) + PW'(wrapped); hit = 1'b1; end
      default:   begin pidx = '0;                        hit = 1'b0; end
    endcase
  end
endmodule

// File: rtl/rrf_bank.sv
module rrf_bank #(
  parameter int DEPTH = 24,
  parameter int DW    = 32,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          rhit,
  input  logic [PW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read-before-write output register
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (rhit) q <= mem[ra];
    else           q <= '0;
  end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int FIX_N = 8,
  parameter int ROT_N = 16,
  parameter int DW    = 32,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_clr,
  input  logic          rotate,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] rd_idx_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [LW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_b
);
  localparam int DEPTH = FIX_N + ROT_N;
  localparam int PW    = $clog2(DEPTH);
  localparam int BW    = (ROT_N > 1) ? $clog2(ROT_N) : 1;
  localparam int NRD   = 2;

  logic [BW-1:0] rot_base;
  logic [PW-1:0] wr_pidx;
  logic          wr_hit;
  logic [LW-1:0] rd_lidx [NRD];
  logic [PW-1:0] rd_pidx [NRD];
  logic          rd_hit  [NRD];
  logic [DW-1:0] rd_q    [NRD];

  assign rd_lidx[0] = rd_idx_a;
  assign rd_lidx[1] = rd_idx_b;
  assign rd_data_a  = rd_q[0];
  assign rd_data_b  = rd_q[1];

  rrf_base_ctr #(.ROT_N(ROT_N), .BW(BW)) u_base (
    .clk (clk),
    .rst (rst),
    .clr (base_clr),
    .step(rotate),
    .base(rot_base)
  );

  rrf_xlate #(.FIX_N(FIX_N), .ROT_N(ROT_N), .LW(LW), .PW(PW), .BW(BW)) u_wxl (
    .lidx(wr_idx),
    .base(rot_base),
    .pidx(wr_pidx),
    .hit (wr_hit)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rrf_xlate #(.FIX_N(FIX_N), .ROT_N(ROT_N), .LW(LW), .PW(PW), .BW(BW)) u_rxl (
      .lidx(rd_lidx[p]),
      .base(rot_base),
      .pidx(rd_pidx[p]),
      .hit (rd_hit[p])
    );

    rrf_bank #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_bank (
      .clk (clk),
      .rst (rst),
      .we  (wr_en && wr_hit),
      .wa  (wr_pidx),
      .wd  (wr_data),
      .rhit(rd_hit[p]),
      .ra  (rd_pidx[p]),
      .q   (rd_q[p])
    );
  end
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter int FIX_N = 8,
  parameter int ROT_N = 16,
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int BW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          base_clr,
  input logic          rotate,
  input logic [LW-1:0] rd_idx_a,
  input logic [LW-1:0] rd_idx_b,
  input logic [DW-1:0] rd_data_a,
  input logic [DW-1:0] rd_data_b,
  input logic [BW-1:0] base
);
  localparam int DEPTH = FIX_N + ROT_N;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (rd_data_a == '0 && rd_data_b == '0));

  // R7
  clear_base_chk: assert property (@(posedge clk) disable iff (rst)
    base_clr |=> (base == '0));

  // R4
  rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rotate && !base_clr) |=>
      (base == (($past(base) == BW'(ROT_N - 1)) ? '0 : $past(base) + 1'b1)));

  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rotate && !base_clr) |=> $stable(base));

  // R10
  base_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(base) < ROT_N));

  // R8
  unmap_a_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_idx_a) >= DEPTH) |=> (rd_data_a == '0));

  // R8
  unmap_b_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_idx_b) >= DEPTH) |=> (rd_data_b == '0));
endmodule

bind rot_regfile rot_regfile_chk #(
  .FIX_N(FIX_N), .ROT_N(ROT_N), .DW(DW), .LW(LW), .BW(BW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .base_clr (base_clr),
  .rotate   (rotate),
  .rd_idx_a (rd_idx_a),
  .rd_idx_b (rd_idx_b),
  .rd_data_a(rd_data_a),
  .rd_data_b(rd_data_b),
  .base     (rot_base)
);

// File: tb/sim_rot_regfile.sv
`timescale 1ns/1ps
module sim_rot_regfile;
  localparam int FIX_N = 8;
  localparam int ROT_N = 16;
  localparam int DW    = 32;
  localparam int LW    = 5;
  localparam int TOT   = FIX_N + ROT_N;
  localparam int NADDR = 1 << LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, base_clr = 1'b0, rotate = 1'b0, wr_en = 1'b0;
  logic [LW-1:0] wr_idx = '0, rd_idx_a = '0, rd_idx_b = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;

  rot_regfile #(.FIX_N(FIX_N), .ROT_N(ROT_N), .DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .base_clr(base_clr), .rotate(rotate),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [DW-1:0] lm [TOT];  // contents as seen by logical number
  int rcnt = 0;             // rotations since base was last zero

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at edge, check at next negedge
  task automatic op(input bit w, input int wa, input logic [DW-1:0] wd,
                    input bit rot, input bit clr, input int ra, input int rb,
                    input string tag);
    logic [DW-1:0] ea, eb;
    logic [DW-1:0] tmp [TOT];
    wr_en = w; wr_idx = LW'(wa); wr_data = wd;
    rotate = rot; base_clr = clr;
    rd_idx_a = LW'(ra); rd_idx_b = LW'(rb);
    ea = (ra < TOT) ? lm[ra] : '0;  // old value even if written now (R6)
    eb = (rb < TOT) ? lm[rb] : '0;
    @(posedge clk);
    if (w && wa < TOT) lm[wa] = wd;
    if (clr) begin
      tmp = lm;
      for (int k = 0; k < ROT_N; k++) lm[FIX_N + k] = tmp[FIX_N + (k + rcnt) % ROT_N];
      rcnt = 0;
    end else if (rot) begin
      tmp = lm;
      for (int k = 0; k < ROT_N; k++) lm[FIX_N + (k + 1) % ROT_N] = tmp[FIX_N + k];
      rcnt = (rcnt + 1) % ROT_N;
    end
    @(negedge clk);
    wr_en = 1'b0; rotate = 1'b0; base_clr = 1'b0;
    chk(tag, rd_data_a, ea);
    chk(tag, rd_data_b, eb);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < TOT; i++) op(0, 0, '0, 0, 0, i, TOT - 1 - i, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset port A", rd_data_a, '0);
    chk("R1 reset port B", rd_data_b, '0);
    rst = 1'b0;
    // fill every mapped register; reads point at unmapped numbers (R8)
    for (int i = 0; i < TOT; i++)
      op(1, i, 32'hA500_0000 + DW'(i * 3 + 1), 0, 0, NADDR - 1, TOT, "R1 R8 fill");
    read_all("R2 R9 readback");
    op(0, 0, '0, 0, 0, 5, 5, "R9 same address both ports");
    // unmapped reads and writes
    for (int i = TOT; i < NADDR; i++) op(1, i, 32'hDEAD_0000 + DW'(i), 0, 0, i, i - TOT, "R8 unmapped");
    read_all("R8 no effect of unmapped writes");
    // same-cycle read of written register, fixed and rotating
    op(1, 3, 32'h1111_0003, 0, 0, 3, 3, "R6 fixed old value");
    op(0, 0, '0, 0, 0, 3, 2, "R6 fixed new value next");
    op(1, FIX_N + 4, 32'h2222_0004, 0, 0, FIX_N + 4, FIX_N + 5, "R6 rot old value");
    op(0, 0, '0, 0, 0, FIX_N + 4, FIX_N + 4, "R6 rot new value next");
    // rotation sweep across wrap
    for (int r = 0; r < ROT_N + 2; r++) begin
      op(0, 0, '0, 1, 0, FIX_N, 0, "R4 R3 rotate");
      read_all("R4 R3 R10 after rotate");
    end
    // write in the rotate cycle
    op(1, FIX_N + 2, 32'h3333_0002, 1, 0, FIX_N + 2, 1, "R5 write with rotate");
    op(0, 0, '0, 0, 0, FIX_N + 3, FIX_N + 2, "R5 shifted slot");
    op(1, FIX_N + ROT_N - 1, 32'h3333_000F, 1, 0, FIX_N, 0, "R5 write top with rotate");
    op(0, 0, '0, 0, 0, FIX_N, FIX_N + ROT_N - 1, "R5 wrapped slot");
    // clear after some rotations, clear wins over rotate
    for (int r = 0; r < 5; r++) op(0, 0, '0, 1, 0, FIX_N + r, r, "R4 pre-clear");
    op(0, 0, '0, 1, 1, FIX_N, 0, "R7 clear with rotate");
    read_all("R7 after clear");
    op(0, 0, '0, 1, 0, FIX_N + 1, 6, "R4 rotate");
    op(1, FIX_N + 7, 32'h4444_0007, 0, 1, FIX_N + 7, 7, "R7 clear with write");
    read_all("R7 after clear with write");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int wa, ra, rb, sel;
      wa  = $urandom_range(NADDR - 1);
      ra  = $urandom_range(NADDR - 1);
      rb  = $urandom_range(NADDR - 1);
      sel = $urandom_range(15);
      if (sel < 3) ra = wa;
      op(sel[0] | sel[1], wa, $urandom(), sel < 6, sel == 15, ra, rb, "R2 R4 R5 R6 R7 mixed");
    end
    read_all("R10 final readback");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule